// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits between a processor register bus and an on-chip flash array and turns software requests into timed program and erase operations. Software first sets a write-once clock divider that turns the bus clock into a slow timing tick. The tick should fall between 150 kHz and 200 kHz, and one tick period is the unit that times every program or erase pulse. Each command then starts with an opening write that carries an array address and a data byte. Software next writes a command code and sets a launch flag. The sequencer holds the operation's enable toward the array for a fixed number of tick periods and ends it with a one-cycle completion strobe.

One command can wait in a holding slot while another runs. When a burst byte-program command waits behind a running byte program and targets the same 64-byte row, it follows without a gap and uses the shorter burst count. Any request out of order sets an access-error flag and throws away the command being assembled. While that flag is set, further commands and divider writes are refused, until software clears the flag by writing 1 to it.

The opening write uses a valid/ready handshake. `open_ready` depends only on internal state and never on `open_valid`. It is high when the holding slot is empty and no access error is pending. While it is low, the source must keep `open_valid`, `open_addr` and `open_data` unchanged. The array itself is not touched directly. Flash cells only clear bits when programmed, so a byte must not be programmed twice without erasing its page or the whole array first; keeping to that rule is left to software.

Top module: `fcmd_seq`

## Requirements
- R1: After reset, status reads 0xC0, the divider register reads 0x00, `arr_op` is 0 and `open_ready` is 1.
- R2: The divider register (address 0: bits 5:0 divide value, bit 6 prescale-by-8, bit 7 read-only "written" flag) takes only the first write after reset; every later write leaves its readback unchanged.
- R3: A divider write while the access-error flag is set is ignored, and the register stays unwritten.
- R4: An opening write accepted before the divider has been written sets the access-error flag, and no array operation follows.
- R5: An opening write transfers on a clock edge with `open_valid` and `open_ready` both high. `open_ready` is low while a command is being assembled or waiting, or while the error flag is set. The latched address and data appear on `arr_addr`/`arr_data` and stay stable for the whole operation.
- R6: Each of the following sets the access-error flag (status bit 5) and discards the command being assembled: a command write with no opening write before it, a second command write, an unknown command code, or a launch before a valid code. No array operation results.
- R7: Writing status (address 1) with bit 5 = 1 clears the access-error flag; writing bit 5 = 0 leaves it set.
- R8: Byte program (code 0x20, launched by writing status bit 7 = 1) drives `arr_op` = 1 for exactly 9 tick periods. `arr_end` pulses in its last cycle.
- R9: One tick period is (D+1) bus cycles, multiplied by 8 when the prescale bit is set, where D is the divide value.
- R10: Page erase (code 0x40) drives `arr_op` = 2 for 4000 tick periods. `arr_addr` is the 512-byte page base of the opening address, and the data is ignored.
- R11: Mass erase (code 0x41) drives `arr_op` = 3 for 20000 tick periods with `arr_addr` = 0.
- R12: Burst program (code 0x25) lasts 4 tick periods only when it starts in the completion cycle of a byte program whose address lies in the same 64-byte row. Otherwise it lasts 9.
- R13: Status bit 7 (slot free) is 0 while a launched command waits. Status bit 6 (idle) is 0 while a command waits or runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 divider, 1 status, 2 command |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (command register reads 0) |
| open_valid | input | 1 | Opening array write is offered |
| open_ready | output | 1 | Opening array write can be taken |
| open_addr | input | 16 | Array byte address of the opening write |
| open_data | input | 8 | Data byte of the opening write |
| arr_op | output | 2 | Active operation: 0 none, 1 program, 2 page erase, 3 mass erase |
| arr_addr | output | 16 | Operation address |
| arr_data | output | 8 | Byte to program (0 for erases) |
| arr_end | output | 1 | Last cycle of the running operation |

## Verification
Two things can land in the same cycle: a running byte program can expire in the very cycle that hands a waiting command to the engine. The bench provokes this by queueing burst commands while a program is running, with a slow tick so the queueing finishes early. It then measures the length of each operation between completion strobes. A same-row follower must last 4 periods and a different-row follower 9. `arr_op` must never drop in between, which the stability assertion checks.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_PERASE = 2'd2,
    OP_MERASE = 2'd3
  } op_t;

  typedef enum logic [1:0] {
    SL_EMPTY  = 2'd0,
    SL_OPEN   = 2'd1,
    SL_CODE   = 2'd2,
    SL_QUEUED = 2'd3
  } slot_t;

  localparam logic [7:0] CMD_PROG   = 8'h20;
  localparam logic [7:0] CMD_BURST  = 8'h25;
  localparam logic [7:0] CMD_PERASE = 8'h40;
  localparam logic [7:0] CMD_MERASE = 8'h41;

  localparam logic [1:0] RA_DIV  = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_CMD  = 2'd2;

  localparam int ST_GO   = 7;
  localparam int ST_IDLE = 6;
  localparam int ST_ERR  = 5;

  function automatic logic code_known(input logic [7:0] c);
    return (c == CMD_PROG) || (c == CMD_BURST) ||
           (c == CMD_PERASE) || (c == CMD_MERASE);
  endfunction

endpackage

// File: rtl/fcmd_tick.sv
module fcmd_tick #(
  parameter int DIV_W    = 6,
  parameter int PRE_MULT = 8   // power of two
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_val,
  input  logic             pre_en,
  output logic             tick
);
  localparam int PRE_W = (PRE_MULT > 1) ? $clog2(PRE_MULT) : 0;
  localparam int CNT_W = DIV_W + PRE_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] lim;

  assign base = CNT_W'(div_val) + CNT_W'(1);
  assign lim  = pre_en ? ((base << PRE_W) - CNT_W'(1)) : (base - CNT_W'(1));
  assign tick = en && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (en)      cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/fcmd_front.sv
module fcmd_front
  import fcmd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DIV_W = 6    // at most 6: bit DIV_W is prescale, bit 7 the written flag
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             open_valid,
  output logic             open_ready,
  input  logic [AW-1:0]    open_addr,
  input  logic [DW-1:0]    open_data,
  input  logic             busy,
  input  logic             q_take,
  output logic             q_valid,
  output logic [7:0]       q_code,
  output logic [AW-1:0]    q_addr,
  output logic [DW-1:0]    q_data,
  output logic [DIV_W-1:0] div_val,
  output logic             pre_en,
  output logic             div_set,
  output logic             accerr
);
  slot_t            slot_q, slot_d;
  logic [7:0]       code_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [DIV_W-1:0] div_q;
  logic             pre_q, set_q, err_q;
  logic             err_set, err_clr;
  logic             wr_div, wr_stat, wr_cmd, open_hs, take_code;

  assign wr_div    = reg_wr && (reg_addr == RA_DIV);
  assign wr_stat   = reg_wr && (reg_addr == RA_STAT);
  assign wr_cmd    = reg_wr && (reg_addr == RA_CMD);
  assign open_ready = (slot_q == SL_EMPTY) && !err_q;
  assign open_hs   = open_valid && open_ready;
  assign take_code = wr_cmd && !err_q && (slot_q == SL_OPEN) && code_known(reg_wdata);

  always_comb begin
    slot_d  = slot_q;
    err_set = 1'b0;
    err_clr = 1'b0;
    if (q_take) slot_d = SL_EMPTY;
    if (open_hs) begin
      if (set_q) slot_d = SL_OPEN;
      else       err_set = 1'b1;
    end
    if (wr_cmd && !err_q) begin
      if (take_code) slot_d = SL_CODE;
      else begin
        err_set = 1'b1;
        if (slot_q != SL_QUEUED) slot_d = SL_EMPTY;
      end
    end
    if (wr_stat) begin
      if (reg_wdata[ST_ERR]) err_clr = 1'b1;
      if (reg_wdata[ST_GO] && !err_q) begin
        if (slot_q == SL_CODE) slot_d = SL_QUEUED;
        else begin
          err_set = 1'b1;
          if (slot_q != SL_QUEUED) slot_d = SL_EMPTY;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SL_EMPTY;
      code_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      div_q  <= '0;
      pre_q  <= 1'b0;
      set_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      slot_q <= slot_d;
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (open_hs && set_q) begin
        addr_q <= open_addr;
        data_q <= open_data;
      end
      if (take_code) code_q <= reg_wdata;
      if (wr_div && !set_q && !err_q) begin
        div_q <= reg_wdata[DIV_W-1:0];
        pre_q <= reg_wdata[DIV_W];
        set_q <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_DIV: begin
        reg_rdata[DIV_W-1:0] = div_q;
        reg_rdata[DIV_W]     = pre_q;
        reg_rdata[7]         = set_q;
      end
      RA_STAT: begin
        reg_rdata[ST_GO]   = (slot_q != SL_QUEUED);
        reg_rdata[ST_IDLE] = (slot_q != SL_QUEUED) && !busy;
        reg_rdata[ST_ERR]  = err_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign q_valid = (slot_q == SL_QUEUED);
  assign q_code  = code_q;
  assign q_addr  = addr_q;
  assign q_data  = data_q;
  assign div_val = div_q;
  assign pre_en  = pre_q;
  assign div_set = set_q;
  assign accerr  = err_q;
endmodule

// File: rtl/fcmd_exec.sv
module fcmd_exec
  import fcmd_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int PAGE_BYTES = 512,
  parameter int ROW_BYTES  = 64,
  parameter int T_PROG     = 9,
  parameter int T_BURST    = 4,
  parameter int T_PAGE     = 4000,
  parameter int T_MASS     = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_valid,
  input  logic [7:0]    q_code,
  input  logic [AW-1:0] q_addr,
  input  logic [DW-1:0] q_data,
  input  logic          tick,
  output logic          q_take,
  output logic          busy,
  output logic          restart,
  output op_t           arr_op,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data,
  output logic          arr_end
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int ROW_LSB  = $clog2(ROW_BYTES);
  localparam int REM_W    = $clog2(T_MASS + 1);

  op_t           op_q, op_n;
  logic [REM_W-1:0] rem_q, len_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n;
  logic          fin, same_row, burst_ok;

  assign busy     = (op_q != OP_NONE);
  assign fin      = busy && tick && (rem_q == REM_W'(1));
  assign q_take   = q_valid && (!busy || fin);
  assign same_row = (q_addr[AW-1:ROW_LSB] == addr_q[AW-1:ROW_LSB]);
  assign burst_ok = fin && (op_q == OP_PROG) && (q_code == CMD_BURST) && same_row;

  always_comb begin
    op_n   = OP_NONE;
    len_n  = REM_W'(T_PROG);
    addr_n = q_addr;
    data_n = '0;
    case (q_code)
      CMD_PROG, CMD_BURST: begin
        op_n   = OP_PROG;
        len_n  = burst_ok ? REM_W'(T_BURST) : REM_W'(T_PROG);
        data_n = q_data;
      end
      CMD_PERASE: begin
        op_n   = OP_PERASE;
        len_n  = REM_W'(T_PAGE);
        addr_n = {q_addr[AW-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
      end
      CMD_MERASE: begin
        op_n   = OP_MERASE;
        len_n  = REM_W'(T_MASS);
        addr_n = '0;
      end
      default: op_n = OP_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      rem_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (q_take) begin
      op_q   <= op_n;
      rem_q  <= len_n;
      addr_q <= addr_n;
      data_q <= data_n;
    end else if (fin) begin
      op_q <= OP_NONE;
    end else if (busy && tick) begin
      rem_q <= rem_q - REM_W'(1);
    end
  end

  assign restart  = q_take;
  assign arr_op   = op_q;
  assign arr_addr = addr_q;
  assign arr_data = data_q;
  assign arr_end  = fin;
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int DIV_W      = 6,
  parameter int PRE_MULT   = 8,
  parameter int PAGE_BYTES = 512,
  parameter int ROW_BYTES  = 64,
  parameter int T_PROG     = 9,
  parameter int T_BURST    = 4,
  parameter int T_PAGE     = 4000,
  parameter int T_MASS     = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          open_valid,
  output logic          open_ready,
  input  logic [AW-1:0] open_addr,
  input  logic [DW-1:0] open_data,
  output logic [1:0]    arr_op,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data,
  output logic          arr_end
);
  logic             q_valid, q_take, busy_w, restart_w, tick_w;
  logic [7:0]       q_code;
  logic [AW-1:0]    q_addr;
  logic [DW-1:0]    q_data;
  logic [DIV_W-1:0] div_val_w;
  logic             pre_en_w, div_set_w, accerr_w;
  op_t              op_w;

  fcmd_front #(.AW(AW), .DW(DW), .DIV_W(DIV_W)) u_front (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .open_valid, .open_ready, .open_addr, .open_data,
    .busy(busy_w), .q_take, .q_valid, .q_code, .q_addr, .q_data,
    .div_val(div_val_w), .pre_en(pre_en_w), .div_set(div_set_w), .accerr(accerr_w)
  );

  fcmd_tick #(.DIV_W(DIV_W), .PRE_MULT(PRE_MULT)) u_tick (
    .clk, .rst_n, .en(busy_w), .restart(restart_w),
    .div_val(div_val_w), .pre_en(pre_en_w), .tick(tick_w)
  );

  fcmd_exec #(
    .AW(AW), .DW(DW), .PAGE_BYTES(PAGE_BYTES), .ROW_BYTES(ROW_BYTES),
    .T_PROG(T_PROG), .T_BURST(T_BURST), .T_PAGE(T_PAGE), .T_MASS(T_MASS)
  ) u_exec (
    .clk, .rst_n, .q_valid, .q_code, .q_addr, .q_data, .tick(tick_w),
    .q_take, .busy(busy_w), .restart(restart_w),
    .arr_op(op_w), .arr_addr, .arr_data, .arr_end
  );

  assign arr_op = op_w;
endmodule

// File: rtl/fcmd_seq_chk.sv
module fcmd_seq_chk #(
  parameter int AW         = 16,
  parameter int DIV_W      = 6,
  parameter int PAGE_BYTES = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       arr_op,
  input logic [AW-1:0]    arr_addr,
  input logic             arr_end,
  input logic             open_ready,
  input logic             accerr,
  input logic             div_set,
  input logic [DIV_W-1:0] div_val,
  input logic             pre_en
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);

  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_op != 2'd0 && !arr_end) |=> (arr_op == $past(arr_op) && $stable(arr_addr))); // R5

  AST_ERR_BLOCKS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    accerr |-> !open_ready); // R6

  AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_op == 2'd2) |-> (arr_addr[PAGE_LSB-1:0] == '0)); // R10

  AST_MASS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_op == 2'd3) |-> (arr_addr == '0)); // R11

  AST_DIV_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    div_set |=> (div_set && $stable(div_val) && $stable(pre_en))); // R2

  AST_NO_OP_BEFORE_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    !div_set |-> (arr_op == 2'd0)); // R4

  AST_END_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    arr_end |-> (arr_op != 2'd0)); // R8
endmodule

bind fcmd_seq fcmd_seq_chk #(.AW(AW), .DIV_W(DIV_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .arr_op(arr_op), .arr_addr(arr_addr), .arr_end(arr_end),
  .open_ready(open_ready), .accerr(accerr_w), .div_set(div_set_w),
  .div_val(div_val_w), .pre_en(pre_en_w)
);

// File: tb/fcmd_seq_bench.sv
module fcmd_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        open_valid = 1'b0;
  logic        open_ready;
  logic [15:0] open_addr = 16'd0;
  logic [7:0]  open_data = 8'd0;
  logic [1:0]  arr_op;
  logic [15:0] arr_addr;
  logic [7:0]  arr_data;
  logic        arr_end;

  always #2.5 clk = ~clk;

  fcmd_seq u_fcmd_seq (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .open_valid, .open_ready, .open_addr, .open_data,
    .arr_op, .arr_addr, .arr_data, .arr_end
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int seg = 0;
  int rec_len[$];
  logic [1:0]  rec_op[$];
  logic [15:0] rec_addr[$];
  logic [7:0]  rec_data[$];
  logic [7:0]  mem[int];

  function automatic logic [7:0] mrd(int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  // monitor: operation lengths and behavioural array
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (arr_op != 2'd0) seg++;
      if (arr_end) begin
        rec_len.push_back(seg);
        rec_op.push_back(arr_op);
        rec_addr.push_back(arr_addr);
        rec_data.push_back(arr_data);
        if (arr_op == 2'd1) mem[int'(arr_addr)] = mrd(int'(arr_addr)) & arr_data;
        else if (arr_op == 2'd2) begin
          for (int i = 0; i < 512; i++) mem.delete(int'(arr_addr) + i);
        end else if (arr_op == 2'd3) mem.delete();
        seg = 0;
      end
    end
  end

  initial begin
    wait (cyc >= 190000);
    errors++;
    $display("FAIL watchdog expired act=%0d exp<190000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic opn(input logic [15:0] a, input logic [7:0] d);
    int n = 0;
    @(negedge clk);
    open_valid = 1'b1; open_addr = a; open_data = d;
    while (!open_ready && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
    open_valid = 1'b0;
  endtask

  task automatic issue(input logic [15:0] a, input logic [7:0] d, input logic [7:0] code);
    opn(a, d);
    wr(2'd2, code);
    wr(2'd1, 8'h80);
  endtask

  task automatic wait_recs(input int n);
    int g = 0;
    while (rec_len.size() < n && g < 60000) begin @(negedge clk); g++; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0; open_valid = 1'b0;
    repeat (3) @(negedge clk);
    rec_len.delete(); rec_op.delete(); rec_addr.delete(); rec_data.delete();
    mem.delete(); seg = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    rd(2'd1, v); chk(v == 8'hC0, "R1 status", v, 8'hC0);
    rd(2'd0, v); chk(v == 8'h00, "R1 divider", v, 8'h00);
    chk(arr_op == 2'd0, "R1 arr_op", arr_op, 0);
    chk(open_ready == 1'b1, "R1 open_ready", open_ready, 1);
  endtask

  task automatic t_errors();
    logic [7:0] v;
    do_reset();
    opn(16'h0100, 8'h12);
    rd(2'd1, v); chk(v == 8'hE0, "R4 error before divider", v, 8'hE0);
    chk(open_ready == 1'b0, "R5 ready low on error", open_ready, 0);
    wr(2'd0, 8'h05);
    rd(2'd0, v); chk(v == 8'h00, "R3 divider refused", v, 8'h00);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk(v == 8'hE0, "R7 zero keeps error", v, 8'hE0);
    wr(2'd1, 8'h20);
    rd(2'd1, v); chk(v == 8'hC0, "R7 clear", v, 8'hC0);
    wr(2'd0, 8'h05);
    rd(2'd0, v); chk(v == 8'h85, "R2 first write", v, 8'h85);
    wr(2'd0, 8'h4A);
    rd(2'd0, v); chk(v == 8'h85, "R2 second write ignored", v, 8'h85);
    wr(2'd2, 8'h20);
    rd(2'd1, v); chk(v == 8'hE0, "R6 command without open", v, 8'hE0);
    wr(2'd1, 8'h20);
    opn(16'h0200, 8'h33);
    wr(2'd1, 8'h80);
    rd(2'd1, v); chk(v == 8'hE0, "R6 launch without code", v, 8'hE0);
    wr(2'd1, 8'h20);
    wr(2'd2, 8'h20);
    rd(2'd1, v); chk(v == 8'hE0, "R6 open discarded", v, 8'hE0);
    wr(2'd1, 8'h20);
    opn(16'h0300, 8'h44);
    wr(2'd2, 8'h77);
    rd(2'd1, v); chk(v == 8'hE0, "R6 unknown code", v, 8'hE0);
    wr(2'd1, 8'h20);
    opn(16'h0300, 8'h44);
    wr(2'd2, 8'h20);
    wr(2'd2, 8'h20);
    rd(2'd1, v); chk(v == 8'hE0, "R6 second command write", v, 8'hE0);
    wr(2'd1, 8'h20);
    repeat (40) @(negedge clk);
    chk(rec_len.size() == 0, "R6 no array op", rec_len.size(), 0);
    chk(arr_op == 2'd0, "R4 array idle", arr_op, 0);
  endtask

  task automatic t_prog();
    logic [7:0] v;
    do_reset();
    wr(2'd0, 8'h01);
    issue(16'h1234, 8'h5A, 8'h20);
    rd(2'd1, v); chk(v == 8'h80, "R13 busy clears idle", v, 8'h80);
    chk(open_ready == 1'b1, "R5 ready while running", open_ready, 1);
    wait_recs(1);
    chk(rec_len.size() == 1, "R8 completed", rec_len.size(), 1);
    if (rec_len.size() == 1) begin
      chk(rec_len[0] == 18, "R8 program length", rec_len[0], 18);
      chk(rec_op[0] == 2'd1, "R8 op code", rec_op[0], 1);
      chk(rec_addr[0] == 16'h1234, "R5 address", rec_addr[0], 16'h1234);
      chk(rec_data[0] == 8'h5A, "R5 data", rec_data[0], 8'h5A);
    end
    chk(mrd(32'h1234) == 8'h5A, "R8 array byte", mrd(32'h1234), 8'h5A);
    @(negedge clk);
    rd(2'd1, v); chk(v == 8'hC0, "R13 idle after", v, 8'hC0);
  endtask

  task automatic t_prescale();
    do_reset();
    wr(2'd0, 8'h42);
    issue(16'h0010, 8'h0F, 8'h20);
    wait_recs(1);
    chk(rec_len.size() == 1 && rec_len[0] == 216, "R9 prescaled period",
        rec_len.size() ? rec_len[0] : -1, 216);
  endtask

  task automatic t_page();
    do_reset();
    wr(2'd0, 8'h00);
    issue(16'h0210, 8'h3C, 8'h20); wait_recs(1);
    issue(16'h0400, 8'h11, 8'h20); wait_recs(2);
    chk(rec_len.size() == 2 && rec_len[0] == 9, "R9 undivided period",
        rec_len.size() ? rec_len[0] : -1, 9);
    issue(16'h03AB, 8'hEE, 8'h40); wait_recs(3);
    if (rec_len.size() == 3) begin
      chk(rec_len[2] == 4000, "R10 page length", rec_len[2], 4000);
      chk(rec_addr[2] == 16'h0200, "R10 page base", rec_addr[2], 16'h0200);
      chk(rec_op[2] == 2'd2, "R10 op code", rec_op[2], 2);
    end else chk(1'b0, "R10 completed", rec_len.size(), 3);
    chk(mrd(32'h0210) == 8'hFF, "R10 page erased", mrd(32'h0210), 8'hFF);
    chk(mrd(32'h0400) == 8'h11, "R10 next page kept", mrd(32'h0400), 8'h11);
  endtask

  task automatic t_mass();
    do_reset();
    wr(2'd0, 8'h00);
    issue(16'h7000, 8'h81, 8'h20); wait_recs(1);
    issue(16'h1357, 8'h00, 8'h41); wait_recs(2);
    if (rec_len.size() == 2) begin
      chk(rec_len[1] == 20000, "R11 mass length", rec_len[1], 20000);
      chk(rec_addr[1] == 16'h0000, "R11 address zero", rec_addr[1], 0);
      chk(rec_op[1] == 2'd3, "R11 op code", rec_op[1], 3);
    end else chk(1'b0, "R11 completed", rec_len.size(), 2);
    chk(mrd(32'h7000) == 8'hFF, "R11 array erased", mrd(32'h7000), 8'hFF);
  endtask

  task automatic t_burst();
    logic [7:0] v;
    do_reset();
    wr(2'd0, 8'h07);                       // 8 cycles per tick
    issue(16'h1000, 8'hA1, 8'h20);
    issue(16'h1001, 8'hB2, 8'h25);
    rd(2'd1, v); chk(v == 8'h00, "R13 queued behind run", v, 8'h00);
    chk(open_ready == 1'b0, "R5 ready low while queued", open_ready, 0);
    wait_recs(1);
    issue(16'h1080, 8'hC3, 8'h25);         // different row, chained
    wait_recs(3);
    issue(16'h1002, 8'hD4, 8'h25);         // not chained
    wait_recs(4);
    if (rec_len.size() == 4) begin
      chk(rec_len[0] == 72, "R12 plain program", rec_len[0], 72);
      chk(rec_len[1] == 32, "R12 same-row burst", rec_len[1], 32);
      chk(rec_len[2] == 72, "R12 other-row burst", rec_len[2], 72);
      chk(rec_len[3] == 72, "R12 unchained burst", rec_len[3], 72);
      chk(rec_addr[1] == 16'h1001, "R12 burst address", rec_addr[1], 16'h1001);
    end else chk(1'b0, "R12 completed", rec_len.size(), 4);
    chk(mrd(32'h1080) == 8'hC3, "R12 array byte", mrd(32'h1080), 8'hC3);
  endtask

  initial begin
    t_reset();
    t_errors();
    t_prog();
    t_prescale();
    t_page();
    t_mass();
    t_burst();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule